// File: doc/BRIEF.md
# Up-Counting Timer with Selectable Trigger Outputs

The block is a free-standing up-counting timer. A clock divider counts input clocks from zero to a programmed divide value. Each time it completes, the main counter steps once. The main counter runs from zero to a programmed top value and then wraps, which raises an update event. The update period is therefore (divide+1)·(top+1) input clocks.

Six compare registers produce internal reference levels. Two independently selected trigger outputs are picked from a set of timing sources:
- the forced-update pulse,
- the run bit,
- the update event,
- a compare pulse,
- the compare reference levels,
- on the second output only, pulses built from edges of those levels.

Software controls the timer through a single-cycle register port. The port has a write strobe, an address and data, plus a combinational read address. The divide value is always held in a shadow register, and the top value can be shadowed too. A write to the event register commits both values at once and restarts the count. This lets a new rate take effect cleanly. The second trigger output and its select field can be left out by a parameter; software then detects their absence by reading the field back.

Top module: `tmr_master`

Register map (4-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 = run, bit 1 = top preload |
| 1 | mode | bits 2:0 = main select, bits 7:4 = aux select |
| 2 | divide | divide value |
| 3 | top | top value |
| 4 | count | main counter |
| 5 | event | write-only; bit 0 forces an update |
| 8 to 13 | compare 1 to 6 | compare values |

## Requirements
- R1: With divide value P and top value T, the divider counts 0..P and the counter counts 0..T and wraps to 0. An update event occurs exactly once every (P+1)·(T+1) clocks while running.
- R2: When control bit 1 (preload) is set, a write to the top register is held until the next update event. When bit 1 is clear, the new top value governs the counter from the next clock.
- R3: A write to the divide register never changes the rate until an update event commits it.
- R4: Writing 1 to bit 0 of the event register forces an update event, even while stopped. After that clock the counter and divider are 0 and both shadowed values are committed.
- R5: The counter advances only while control bit 0 (run) is 1. With run at 0 it holds its value.
- R6: The count register can be read at any time, and a write to it sets the counter at the next clock.
- R7: Main select codes are: 0 = forced-update pulse, 1 = run level, 2 = update-event pulse, 3 = one-clock pulse when the counter steps onto the compare-1 value.
- R8: Main select codes 4..7 give compare references 1..4. Reference n is high while the count is at or above compare register n.
- R9: The aux select codes 0..7 act as for the main output, and codes 8 and 9 give compare references 5 and 6.
- R10: Aux codes 10..15 are edge pulses: 10 = any edge of reference 4, 11 = any edge of reference 6, 12 = rise of 4 or rise of 6, 13 = rise of 4 or fall of 6, 14 = rise of 5 or rise of 6, 15 = rise of 5 or fall of 6.
- R11: Both trigger outputs are registered, so they show their selected source one clock after it.
- R12: When the aux output is not built, the aux select field reads back as 0 whatever was written and the aux output stays 0. The main select field keeps its value.
- R13: After reset the counter reads 0, the top register reads all ones, the mode register reads 0, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | DW | Read data for rd_addr, combinational |
| trig_main | output | 1 | Main trigger output |
| trig_aux | output | 1 | Second trigger output (0 when not built) |

## Verification
The rate is tried with a table of divide and top pairs that includes both values at zero, a divider-only division and a counter-only division. Counting update pulses over a whole number of periods separates a correct product (P+1)·(T+1) from off-by-one and swapped-term errors. Preload on and off is told apart by the count two clocks after a restart: with the old top it keeps rising, with the new top it wraps. The edge-combined aux codes are distinguished by the counter value read when the first pulse appears. That value shows whether a rise or a fall was picked, and of which reference. A second instance without the aux output checks the read-back detection.

// File: rtl/tmr_master_pkg.sv
`timescale 1ns/1ps
package tmr_master_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_CMP = 6;
  localparam int NUM_SRC = 16;

  localparam logic [ADDR_W-1:0] ADR_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE     = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_DIV      = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_TOP      = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_COUNT    = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_EVENT    = 4'd5;
  localparam int                ADR_CMP_BASE = 8;

  // address of compare register i (0-based)
  function automatic logic [ADDR_W-1:0] cmp_slot(input int i);
    return ADDR_W'(ADR_CMP_BASE + i);
  endfunction

  // pick one timing source by its select code
  function automatic logic pick_src(input logic [3:0] sel, input logic [NUM_SRC-1:0] src);
    return src[sel];
  endfunction
endpackage

// File: rtl/tmr_master_regs.sv
`timescale 1ns/1ps
module tmr_master_regs
  import tmr_master_pkg::*;
#(
  parameter int DW        = 16,
  parameter bit HAS_AUX   = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DW-1:0]               wr_data,
  input  logic [ADDR_W-1:0]           rd_addr,
  input  logic [DW-1:0]               cnt_q,
  output logic [DW-1:0]               rd_data,
  output logic                        run,
  output logic                        preload,
  output logic [2:0]                  sel_main,
  output logic [3:0]                  sel_aux,
  output logic [DW-1:0]               div_pend,
  output logic [DW-1:0]               top_pend,
  output logic                        top_direct,
  output logic                        force_upd,
  output logic                        cnt_wr,
  output logic [NUM_CMP-1:0][DW-1:0]  cmp
);
  assign force_upd  = wr_en && (wr_addr == ADR_EVENT) && wr_data[0];
  assign cnt_wr     = wr_en && (wr_addr == ADR_COUNT);
  assign top_direct = wr_en && (wr_addr == ADR_TOP) && !preload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      preload  <= 1'b0;
      sel_main <= '0;
      div_pend <= '0;
      top_pend <= '1;
    end else if (wr_en) begin
      case (wr_addr)
        ADR_CTRL: begin
          run     <= wr_data[0];
          preload <= wr_data[1];
        end
        ADR_MODE: sel_main <= wr_data[2:0];
        ADR_DIV:  div_pend <= wr_data;
        ADR_TOP:  top_pend <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp[i] <= '0;
      else if (wr_en && (wr_addr == cmp_slot(i))) cmp[i] <= wr_data;
    end
  end

  if (HAS_AUX) begin : g_aux_sel
    logic [3:0] sel_aux_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_aux_q <= '0;
      else if (wr_en && (wr_addr == ADR_MODE)) sel_aux_q <= wr_data[7:4];
    end
    assign sel_aux = sel_aux_q;
  end else begin : g_no_aux_sel
    assign sel_aux = '0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADR_CTRL:  rd_data = DW'({preload, run});
      ADR_MODE:  rd_data = DW'({sel_aux, 1'b0, sel_main});
      ADR_DIV:   rd_data = div_pend;
      ADR_TOP:   rd_data = top_pend;
      ADR_COUNT: rd_data = cnt_q;
      default: begin
        for (int i = 0; i < NUM_CMP; i++)
          if (rd_addr == cmp_slot(i)) rd_data = cmp[i];
      end
    endcase
  end
endmodule

// File: rtl/tmr_master_cnt.sv
`timescale 1ns/1ps
module tmr_master_cnt #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          force_upd,
  input  logic [DW-1:0] div_pend,
  input  logic [DW-1:0] top_pend,
  input  logic          top_direct,
  input  logic [DW-1:0] top_wval,
  input  logic          cnt_wr,
  input  logic [DW-1:0] cnt_wval,
  input  logic [DW-1:0] cmp_first,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] div_q,
  output logic [DW-1:0] div_act,
  output logic [DW-1:0] top_act,
  output logic          tick,
  output logic          wrap,
  output logic          upd_evt,
  output logic          cmp_hit
);
  // value the counter takes on a step
  function automatic logic [DW-1:0] step_val(input logic [DW-1:0] cur, input logic [DW-1:0] top);
    return (cur == top) ? '0 : cur + 1'b1;
  endfunction

  logic [DW-1:0] cnt_nxt;

  assign tick    = run && (div_q == div_act);
  assign wrap    = tick && (cnt_q == top_act);
  assign upd_evt = wrap || force_upd;
  assign cnt_nxt = step_val(cnt_q, top_act);
  assign cmp_hit = tick && !force_upd && !cnt_wr && (cnt_nxt == cmp_first);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (force_upd) begin
      cnt_q <= '0;
      div_q <= '0;
    end else begin
      if (run) div_q <= tick ? '0 : div_q + 1'b1;
      if (cnt_wr)    cnt_q <= cnt_wval;
      else if (tick) cnt_q <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_act <= '0;
      top_act <= '1;
    end else begin
      if (upd_evt) begin
        div_act <= div_pend;
        top_act <= top_pend;
      end
      if (top_direct) top_act <= top_wval;
    end
  end
endmodule

// File: rtl/tmr_master_msel.sv
`timescale 1ns/1ps
module tmr_master_msel
  import tmr_master_pkg::*;
#(
  parameter int DW      = 16,
  parameter bit HAS_AUX = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DW-1:0]              cnt_q,
  input  logic [NUM_CMP-1:0][DW-1:0] cmp,
  input  logic                       force_upd,
  input  logic                       run,
  input  logic                       upd_evt,
  input  logic                       cmp_hit,
  input  logic [2:0]                 sel_main,
  input  logic [3:0]                 sel_aux,
  output logic [NUM_CMP-1:0]         cmp_ref,
  output logic                       trig_main,
  output logic                       trig_aux
);
  function automatic logic at_or_above(input logic [DW-1:0] c, input logic [DW-1:0] lim);
    return c >= lim;
  endfunction

  logic [NUM_CMP-1:0] ref_q, ref_rise, ref_fall;
  logic [NUM_SRC-1:0] src;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_ref
    assign cmp_ref[i] = at_or_above(cnt_q, cmp[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_q <= '1;
    else        ref_q <= cmp_ref;
  end

  assign ref_rise = cmp_ref & ~ref_q;
  assign ref_fall = ~cmp_ref & ref_q;

  always_comb begin
    src      = '0;
    src[0]   = force_upd;
    src[1]   = run;
    src[2]   = upd_evt;
    src[3]   = cmp_hit;
    src[7:4] = cmp_ref[3:0];
    src[8]   = cmp_ref[4];
    src[9]   = cmp_ref[5];
    src[10]  = ref_rise[3] | ref_fall[3];
    src[11]  = ref_rise[5] | ref_fall[5];
    src[12]  = ref_rise[3] | ref_rise[5];
    src[13]  = ref_rise[3] | ref_fall[5];
    src[14]  = ref_rise[4] | ref_rise[5];
    src[15]  = ref_rise[4] | ref_fall[5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_main <= 1'b0;
    else        trig_main <= pick_src({1'b0, sel_main}, src);
  end

  if (HAS_AUX) begin : g_aux
    logic aux_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) aux_q <= 1'b0;
      else        aux_q <= pick_src(sel_aux, src);
    end
    assign trig_aux = aux_q;
  end else begin : g_no_aux
    assign trig_aux = 1'b0;
  end
endmodule

// File: rtl/tmr_master.sv
`timescale 1ns/1ps
module tmr_master
  import tmr_master_pkg::*;
#(
  parameter int DW      = 16,
  parameter bit HAS_AUX = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              trig_main,
  output logic              trig_aux
);
  logic                       run, preload, top_direct, force_upd, cnt_wr;
  logic [2:0]                 sel_main;
  logic [3:0]                 sel_aux;
  logic [DW-1:0]              div_pend, top_pend, cnt_q, div_q, div_act, top_act;
  logic [NUM_CMP-1:0][DW-1:0] cmp;
  logic [NUM_CMP-1:0]         cmp_ref;
  logic                       tick, wrap, upd_evt, cmp_hit;

  tmr_master_regs #(.DW(DW), .HAS_AUX(HAS_AUX)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cnt_q(cnt_q), .rd_data(rd_data), .run(run), .preload(preload),
    .sel_main(sel_main), .sel_aux(sel_aux), .div_pend(div_pend), .top_pend(top_pend),
    .top_direct(top_direct), .force_upd(force_upd), .cnt_wr(cnt_wr), .cmp(cmp)
  );

  tmr_master_cnt #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .force_upd(force_upd),
    .div_pend(div_pend), .top_pend(top_pend), .top_direct(top_direct), .top_wval(wr_data),
    .cnt_wr(cnt_wr), .cnt_wval(wr_data), .cmp_first(cmp[0]),
    .cnt_q(cnt_q), .div_q(div_q), .div_act(div_act), .top_act(top_act),
    .tick(tick), .wrap(wrap), .upd_evt(upd_evt), .cmp_hit(cmp_hit)
  );

  tmr_master_msel #(.DW(DW), .HAS_AUX(HAS_AUX)) u_msel (
    .clk(clk), .rst_n(rst_n), .cnt_q(cnt_q), .cmp(cmp), .force_upd(force_upd),
    .run(run), .upd_evt(upd_evt), .cmp_hit(cmp_hit), .sel_main(sel_main),
    .sel_aux(sel_aux), .cmp_ref(cmp_ref), .trig_main(trig_main), .trig_aux(trig_aux)
  );
endmodule

// File: rtl/tmr_master_chk.sv
`timescale 1ns/1ps
module tmr_master_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          force_upd,
  input logic          cnt_wr,
  input logic [DW-1:0] cnt_q,
  input logic [DW-1:0] div_q,
  input logic [DW-1:0] div_act,
  input logic          wrap,
  input logic          upd_evt,
  input logic          cmp_hit,
  input logic [2:0]    sel_main,
  input logic          trig_main
);
  // R5: stopped counter holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !force_upd && !cnt_wr) |=> $stable(cnt_q));

  // R4: forced update restarts counter and divider
  a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
    force_upd |=> (cnt_q == '0 && div_q == '0));

  // R1: counter wraps to zero after the top value
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !force_upd && !cnt_wr) |=> (cnt_q == '0));

  // R1: divider never passes its committed value
  a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= div_act);

  // R7: update select follows the update event one clock later
  a_r7_upd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_main == 3'd2 && upd_evt) |=> trig_main);

  // R7: compare-pulse select is low without a compare hit
  a_r7_cmp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_main == 3'd3 && !cmp_hit) |=> !trig_main);

  // R11: run-level select is the run bit delayed by one clock
  a_r11_run_level: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_main == 3'd1) |=> (trig_main == $past(run)));
endmodule

bind tmr_master tmr_master_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .force_upd(force_upd), .cnt_wr(cnt_wr),
  .cnt_q(cnt_q), .div_q(div_q), .div_act(div_act), .wrap(wrap), .upd_evt(upd_evt),
  .cmp_hit(cmp_hit), .sel_main(sel_main), .trig_main(trig_main)
);

// File: tb/tmr_master_tb.sv
`timescale 1ns/1ps
module tmr_master_tb;
  import tmr_master_pkg::*;

  localparam int DW = 16;
  localparam int NV = 5;
  // rate table: divide value, top value, number of periods in the window
  localparam int VP [NV] = '{0, 0, 2, 3, 1};
  localparam int VT [NV] = '{0, 4, 3, 0, 6};
  localparam int VK [NV] = '{5, 4, 3, 6, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [DW-1:0]     rd_data, rd_data_b;
  logic              trig_main, trig_aux, trig_main_b, trig_aux_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit saw_aux_b = 1'b0;

  tmr_master #(.DW(DW), .HAS_AUX(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .trig_main(trig_main), .trig_aux(trig_aux)
  );

  tmr_master #(.DW(DW), .HAS_AUX(1'b0)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data_b), .trig_main(trig_main_b), .trig_aux(trig_aux_b)
  );

  always @(negedge clk) if (rst_n && trig_aux_b) saw_aux_b = 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic count_high(input bit aux, input int n, output int c);
    c = 0;
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      if (aux ? trig_aux : trig_main) c++;
    end
  endtask

  // first counter value seen while the aux output is high
  task automatic first_aux(output int v);
    v = -1;
    for (int i = 0; i < 24; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (trig_aux) begin
        rd(ADR_COUNT, v);
        break;
      end
    end
  endtask

  // stop, top 9, divide 0, given mode, restart, run
  task automatic start_mode(input logic [DW-1:0] mode);
    wr(ADR_CTRL, 16'd0);
    wr(ADR_DIV, 16'd0);
    wr(ADR_TOP, 16'd9);
    wr(ADR_MODE, mode);
    wr(ADR_EVENT, 16'd1);
    wr(ADR_CTRL, 16'd1);
    idle(2);
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int v, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R13 reset state
    check("R13 main out", int'(trig_main), 0);
    check("R13 aux out", int'(trig_aux), 0);
    rd(ADR_COUNT, v); check("R13 count", v, 0);
    rd(ADR_TOP, v);   check("R13 top", v, 16'hFFFF);
    rd(ADR_MODE, v);  check("R13 mode", v, 0);

    // R1 rate table
    for (int i = 0; i < NV; i++) begin
      wr(ADR_CTRL, 16'd0);
      wr(ADR_DIV, DW'(VP[i]));
      wr(ADR_TOP, DW'(VT[i]));
      wr(ADR_MODE, 16'h0002);
      wr(ADR_CTRL, 16'd1);
      wr(ADR_EVENT, 16'd1);
      idle(1);
      count_high(1'b0, VK[i] * (VP[i] + 1) * (VT[i] + 1), c);
      check($sformatf("R1 rate p=%0d t=%0d", VP[i], VT[i]), c, VK[i]);
    end

    // R2 preload set: new top waits for an update
    wr(ADR_CTRL, 16'd0);
    wr(ADR_DIV, 16'd0);
    wr(ADR_TOP, 16'd9);
    wr(ADR_EVENT, 16'd1);
    wr(ADR_CTRL, 16'd2);
    wr(ADR_TOP, 16'd3);
    wr(ADR_COUNT, 16'd2);
    wr(ADR_CTRL, 16'd3);
    idle(2);
    rd(ADR_COUNT, v); check("R2 preload holds old top", v, 4);
    // R2 preload clear: new top acts at once
    wr(ADR_CTRL, 16'd0);
    wr(ADR_TOP, 16'd3);
    wr(ADR_COUNT, 16'd2);
    wr(ADR_CTRL, 16'd1);
    idle(2);
    rd(ADR_COUNT, v); check("R2 direct top wraps", v, 0);

    // R5 stopped counter holds
    wr(ADR_CTRL, 16'd0);
    rd(ADR_COUNT, c);
    idle(5);
    rd(ADR_COUNT, v); check("R5 hold while stopped", v, c);

    // R6 count write
    wr(ADR_COUNT, 16'd6);
    rd(ADR_COUNT, v); check("R6 count write", v, 6);

    // R3 divide value is shadowed
    wr(ADR_TOP, 16'd9);
    wr(ADR_EVENT, 16'd1);
    wr(ADR_DIV, 16'd3);
    wr(ADR_CTRL, 16'd1);
    idle(4);
    rd(ADR_COUNT, v); check("R3 divide not yet committed", v, 4);
    // R4 forced update restarts and commits
    wr(ADR_EVENT, 16'd1);
    rd(ADR_COUNT, v); check("R4 restart to zero", v, 0);
    idle(4);
    rd(ADR_COUNT, v); check("R4 divide committed", v, 1);

    // R7 code 0: forced-update pulse, one clock
    wr(ADR_CTRL, 16'd0);
    wr(ADR_DIV, 16'd0);
    wr(ADR_MODE, 16'h0000);
    wr(ADR_EVENT, 16'd1);
    check("R7 force pulse high", int'(trig_main), 1);
    idle(1);
    check("R7 force pulse ends", int'(trig_main), 0);

    // R11 code 1: run level one clock late
    wr(ADR_MODE, 16'h0001);
    wr(ADR_CTRL, 16'd1);
    check("R11 run level delayed", int'(trig_main), 0);
    idle(1);
    check("R11 run level high", int'(trig_main), 1);

    // compare values: cmp1=3, cmp4=8, cmp6=5
    wr(cmp_slot(0), 16'd3);
    wr(cmp_slot(3), 16'd8);
    wr(cmp_slot(5), 16'd5);

    // R7 code 3: one compare pulse per period
    start_mode(16'h0003);
    count_high(1'b0, 20, c); check("R7 compare pulses", c, 2);
    // R8 code 4: ref1 high 7 of 10
    start_mode(16'h0004);
    count_high(1'b0, 10, c); check("R8 ref1 level", c, 7);
    // R8 code 7: ref4 high 2 of 10
    start_mode(16'h0007);
    count_high(1'b0, 10, c); check("R8 ref4 level", c, 2);
    // R9 aux code 9: ref6 high 5 of 10
    start_mode(16'h0090);
    count_high(1'b1, 10, c); check("R9 aux ref6 level", c, 5);

    // R10 code 10: both edges of ref4 (cmp4=3)
    wr(cmp_slot(3), 16'd3);
    start_mode(16'h00A0);
    count_high(1'b1, 10, c); check("R10 ref4 any edge", c, 2);

    // R10 rise/fall selection, cmp4=10 (never high), cmp5=4, cmp6=7
    wr(cmp_slot(3), 16'd10);
    wr(cmp_slot(4), 16'd4);
    wr(cmp_slot(5), 16'd7);
    start_mode(16'h00C0);
    first_aux(v); check("R10 code12 ref6 rise", v, 8);
    start_mode(16'h00D0);
    first_aux(v); check("R10 code13 ref6 fall", v, 1);
    start_mode(16'h00F0);
    first_aux(v); check("R10 code15 ref5 rise", v, 5);

    // R12 absent aux: field reads zero
    wr(ADR_MODE, 16'h00F7);
    rd(ADR_MODE, v);
    check("R12 built aux field", v, 16'h00F7);
    check("R12 absent aux field", int'(rd_data_b), 16'h0007);
    idle(12);
    check("R12 absent aux output", int'(saw_aux_b), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule